// File: doc/BRIEF.md
# Windowed Multiplicity Coincidence Trigger

This block watches a bank of discriminated trigger lines and decides "trigger" when enough distinct lines have produced a rising edge within a short, programmable coincidence window. Two settings sets, one for physics and one for calibration, each hold a multiplicity threshold and a window length. A select input chooses which set is active. Every timing setting `x` counts 4 ns clock cycles and means `x + 2` cycles.

After a decision the block starts a dead time, during which the lines are ignored. It also starts two independent delay counters. One drives a one-cycle trigger pulse and the other drives a one-cycle time-marker pulse. A new decision is refused until the dead time has ended and both delayed pulses are no longer pending. A veto input holds decisions off. The pulses reach the outputs only while the run input is high. A 32-bit counter counts every decision, whatever the run input is, and it clears whenever the run input changes level, which covers both start of run and stop of run.

Top module: `coinc_trigger`

## Requirements
- R1: A line contributes when it goes from low at one clock edge to high at the next. Each line counts at most once per window. A line held high, or pulsed a second time inside the same window, adds nothing more. A decision occurs in the cycle where the number of contributing lines reaches the active threshold.
- R2: A window opens at the first accepted rising edge. With window setting `x` it spans `x + 2` cycles, counted from and including the opening cycle. An edge at offset `x + 1` from the opening edge still counts. An edge at offset `x + 2` falls into a new window.
- R3: A threshold of 0 behaves as 1. Any threshold above the number of lines (40) never produces a decision.
- R4: With `cal_sel_i` = 1 the calibration threshold and window apply. With `cal_sel_i` = 0 the physics pair applies.
- R5: A decision can only occur in a cycle with `veto_i` low. An edge set that qualifies only while veto is high is neither counted nor pulsed.
- R6: With dead-time setting `d`, the `d + 2` cycles following a decision cycle are blind. Edges in them neither open nor extend a window.
- R7: `trig_o` is a one-cycle pulse exactly `t + 2` cycles after the decision cycle, where `t` is the trigger delay setting. `tmark_o` is a one-cycle pulse exactly `m + 2` cycles after the decision cycle, where `m` is the time-marker delay setting.
- R8: While a delayed pulse is pending, no new decision is accepted: edges in cycles 1 to `t + 1` after a decision are ignored. The firing cycle `t + 2` itself accepts edges again.
- R9: A pulse appears on `trig_o` or `tmark_o` only if `run_i` was high at the clock edge where it fires. Decisions made while `run_i` is low are still counted.
- R10: `dec_count_o` rises by exactly one on each decision, visible one cycle after the decision cycle. It returns to 0 one cycle after any change of `run_i`.
- R11: After reset both pulse outputs are low and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4 ns timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 40 | Discriminated trigger lines |
| run_i | input | 1 | Running state; enables outputs; a level change clears the counter |
| veto_i | input | 1 | Holds decisions off |
| cal_sel_i | input | 1 | 1 selects calibration settings, 0 physics |
| mult_phys_i | input | 6 | Physics threshold (0 to 40) |
| mult_cal_i | input | 6 | Calibration threshold (0 to 40) |
| win_phys_i | input | 4 | Physics window setting x (x+2 cycles) |
| win_cal_i | input | 4 | Calibration window setting x |
| dead_i | input | 16 | Dead-time setting d (d+2 cycles) |
| trig_dly_i | input | 10 | Trigger output delay setting t |
| tmark_dly_i | input | 10 | Time-marker delay setting m |
| trig_o | output | 1 | Delayed trigger pulse |
| tmark_o | output | 1 | Delayed time-marker pulse |
| dec_count_o | output | 32 | Decision counter |

## Verification
The bench places the last edge of a pair exactly on the final cycle of a window and one cycle past it. A design off by one in the window length would decide in both cases or in neither. It pulses a single line twice within one window, and holds another line high. A design that counts levels or repeated edges would decide falsely. Edges are placed on the last blind cycle after a decision and on the first open cycle, for both the dead time and the pending delay. A design with a wrong blind span would drop or accept the wrong edge. If blind-period edges could open a window, the design would pair such an edge with a later one. Random bursts sweep threshold, window, spacing and settings set against a closed-form prediction. Directed cases cover thresholds 0, 40 and 41, veto, the run gate and counter clearing.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum int unsigned {
    OUT_TRIG  = 0,
    OUT_TMARK = 1
  } out_sel_e;

  localparam int unsigned NUM_OUT = 2;
  localparam int unsigned TIME_OFFSET = 2;  // setting x means x+2 cycles
endpackage

// File: rtl/coinc_window.sv
module coinc_window #(
  parameter int unsigned NLINES = 40,
  parameter int unsigned MULT_W = 6,
  parameter int unsigned WIN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] lines_i,
  input  logic              block_i,
  input  logic              veto_i,
  input  logic [MULT_W-1:0] need_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic              dec_o
);
  localparam int unsigned HIT_W = $clog2(NLINES + 1);
  localparam int unsigned WC_W  = WIN_W + 1;

  logic [NLINES-1:0] prev_q, seen_q, rise, acc;
  logic [WC_W-1:0]   win_q;
  logic              open_w;
  logic [HIT_W-1:0]  hits;
  logic [MULT_W-1:0] need_eff;

  always_comb begin
    rise   = lines_i & ~prev_q;
    open_w = |win_q;
    if (block_i)     acc = '0;
    else if (open_w) acc = seen_q | rise;
    else             acc = rise;
    hits = '0;
    for (int i = 0; i < NLINES; i++) hits = hits + HIT_W'(acc[i]);
    need_eff = (need_i == '0) ? MULT_W'(1) : need_i;
    dec_o    = !block_i && !veto_i && (32'(hits) >= 32'(need_eff));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= '0;
      win_q  <= '0;
    end else begin
      prev_q <= lines_i;
      if (dec_o) begin
        seen_q <= '0;
        win_q  <= '0;
      end else if (open_w) begin
        win_q  <= win_q - WC_W'(1);
        seen_q <= (win_q == WC_W'(1)) ? '0 : acc;
      end else if (|acc) begin
        // opening cycle counts as the first of x+2
        seen_q <= acc;
        win_q  <= WC_W'(win_i) + WC_W'(1);
      end
    end
  end
endmodule

// File: rtl/coinc_countdown.sv
module coinc_countdown #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int unsigned NLINES = 40,
  parameter int unsigned MULT_W = 6,
  parameter int unsigned WIN_W  = 4,
  parameter int unsigned DEAD_W = 16,
  parameter int unsigned DLY_W  = 10,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] lines_i,
  input  logic              run_i,
  input  logic              veto_i,
  input  logic              cal_sel_i,
  input  logic [MULT_W-1:0] mult_phys_i,
  input  logic [MULT_W-1:0] mult_cal_i,
  input  logic [WIN_W-1:0]  win_phys_i,
  input  logic [WIN_W-1:0]  win_cal_i,
  input  logic [DEAD_W-1:0] dead_i,
  input  logic [DLY_W-1:0]  trig_dly_i,
  input  logic [DLY_W-1:0]  tmark_dly_i,
  output logic              trig_o,
  output logic              tmark_o,
  output logic [CNT_W-1:0]  dec_count_o
);
  localparam int unsigned DEAD_CW = DEAD_W + 1;
  localparam int unsigned DLY_CW  = DLY_W + 1;

  logic               dec_w, block_w, dead_busy, dead_last;
  logic [MULT_W-1:0]  need_w;
  logic [WIN_W-1:0]   win_w;
  logic [DEAD_CW-1:0] dead_val;
  logic [DLY_CW-1:0]  dly_val [NUM_OUT];
  logic [NUM_OUT-1:0] dly_busy, dly_last, out_q;
  logic               run_q;
  logic [CNT_W-1:0]   cnt_q;

  always_comb begin
    need_w   = cal_sel_i ? mult_cal_i : mult_phys_i;
    win_w    = cal_sel_i ? win_cal_i  : win_phys_i;
    dead_val = DEAD_CW'(dead_i) + DEAD_CW'(TIME_OFFSET);
    // fire register adds one cycle, so load one less than x+2
    dly_val[OUT_TRIG]  = DLY_CW'(trig_dly_i)  + DLY_CW'(TIME_OFFSET - 1);
    dly_val[OUT_TMARK] = DLY_CW'(tmark_dly_i) + DLY_CW'(TIME_OFFSET - 1);
    block_w  = dead_busy | (|dly_busy);
  end

  coinc_window #(
    .NLINES(NLINES), .MULT_W(MULT_W), .WIN_W(WIN_W)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (lines_i),
    .block_i (block_w),
    .veto_i  (veto_i),
    .need_i  (need_w),
    .win_i   (win_w),
    .dec_o   (dec_w)
  );

  coinc_countdown #(.W(DEAD_CW)) u_dead (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dec_w),
    .val_i  (dead_val),
    .busy_o (dead_busy),
    .last_o (dead_last)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_dly
    coinc_countdown #(.W(DLY_CW)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (dec_w),
      .val_i  (dly_val[g]),
      .busy_o (dly_busy[g]),
      .last_o (dly_last[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= dly_last & {NUM_OUT{run_i}};
      run_q <= run_i;
      if (run_i != run_q) cnt_q <= '0;
      else if (dec_w)     cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign trig_o      = out_q[OUT_TRIG];
  assign tmark_o     = out_q[OUT_TMARK];
  assign dec_count_o = cnt_q;

  logic unused_w;
  assign unused_w = dead_last;
endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             veto_i,
  input logic             trig_o,
  input logic             tmark_o,
  input logic             dec_i,
  input logic             block_i,
  input logic [CNT_W-1:0] count_i
);
  p_clear_on_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i != $past(run_i)) |=> (count_i == '0));

  p_count_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_i == $past(count_i) || count_i == $past(count_i) + CNT_W'(1) || count_i == '0));

  p_dec_blinds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> block_i);

  p_veto_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    veto_i |=> (count_i == $past(count_i) || count_i == '0));

  p_trig_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(run_i));

  p_tmark_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmark_o |-> $past(run_i));

  p_trig_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_tmark_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmark_o |=> !tmark_o);
endmodule

bind coinc_trigger coinc_trigger_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .veto_i  (veto_i),
  .trig_o  (trig_o),
  .tmark_o (tmark_o),
  .dec_i   (dec_w),
  .block_i (block_w),
  .count_i (dec_count_o)
);

// File: tb/sim_coinc_trigger.sv
`timescale 1ns/1ps
module sim_coinc_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] lines = '0;
  logic        run = 1'b1, veto = 1'b0, cal_sel = 1'b0;
  logic [5:0]  mult_phys = 6'd1, mult_cal = 6'd1;
  logic [3:0]  win_phys = '0, win_cal = '0;
  logic [15:0] dead = '0;
  logic [9:0]  tdly = '0, mdly = '0;
  logic        trig_o, tmark_o;
  logic [31:0] cnt;

  int checks = 0, fails = 0, trig_n = 0, tm_n = 0;
  bit done = 0;

  always #5 clk = ~clk;

  coinc_trigger u0 (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .run_i(run), .veto_i(veto),
    .cal_sel_i(cal_sel), .mult_phys_i(mult_phys), .mult_cal_i(mult_cal),
    .win_phys_i(win_phys), .win_cal_i(win_cal), .dead_i(dead),
    .trig_dly_i(tdly), .tmark_dly_i(mdly), .trig_o(trig_o), .tmark_o(tmark_o),
    .dec_count_o(cnt)
  );

  always @(negedge clk) if (rst_n) begin
    if (trig_o)  trig_n++;
    if (tmark_o) tm_n++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int np, input int wp, input int nc, input int wc,
                     input int d, input int t, input int m);
    mult_phys = 6'(np); win_phys = 4'(wp); mult_cal = 6'(nc); win_cal = 4'(wc);
    dead = 16'(d); tdly = 10'(t); mdly = 10'(m);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // k distinct lines from base, line j rising at cycle j*s, one cycle each
  task automatic burst(input int base, input int k, input int s);
    int last = (k - 1) * s;
    for (int c = 0; c <= last; c++) begin
      logic [39:0] v = '0;
      for (int j = 0; j < k; j++) if (j * s == c) v[(base + j) % 40] = 1'b1;
      @(negedge clk); lines = v;
    end
    @(negedge clk); lines = '0;
  endtask

  task automatic edges3(input logic [39:0] a, input logic [39:0] b, input int ob,
                        input logic [39:0] c, input int oc);
    @(negedge clk); lines = a;
    for (int i = 1; i <= oc; i++) begin
      @(negedge clk);
      lines = (i == ob ? b : '0) | (i == oc ? c : '0);
    end
    @(negedge clk); lines = '0;
  endtask

  function automatic int predict(input int n, input int k, input int s, input int x);
    int ne = (n == 0) ? 1 : n;
    if (ne > 40 || k < ne) return 0;
    return ((ne - 1) * s <= x + 1) ? 1 : 0;
  endfunction

  task automatic burst_chk(input string req, input int base, input int k, input int s, input int exp);
    longint c0 = cnt; int t0 = trig_n;
    burst(base, k, s);
    idle(60);
    check({req, " count"}, cnt, c0 + exp);
    check({req, " trig"}, trig_n, t0 + exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    idle(3);
    check("R11 trig reset", trig_o, 0);
    check("R11 tmark reset", tmark_o, 0);
    rst_n = 1'b1;
    idle(3);
    check("R11 count after reset", cnt, 0);

    // R7 exact pulse timing, R10 single step
    begin
      longint c0; int bt = 0, bm = 0;
      cfg(3, 1, 1, 0, 0, 5, 9);
      idle(2);
      c0 = cnt;
      @(negedge clk); lines = 40'h7;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        if (k == 1) begin lines = '0; check("R10 count step", cnt, c0 + 1); end
        if (trig_o != (k == 7)) bt++;
        if (tmark_o != (k == 11)) bm++;
      end
      check("R7 trig timing errors", bt, 0);
      check("R7 tmark timing errors", bm, 0);
    end

    // R2 window boundary, W = 4
    cfg(2, 2, 1, 0, 30, 3, 4);
    burst_chk("R2 edge at last window cycle", 3, 2, 3, 1);
    burst_chk("R2 edge one past window", 3, 2, 4, 0);

    // R1 same line twice, held line
    begin
      longint c0;
      cfg(2, 15, 1, 0, 30, 3, 4);
      c0 = cnt;
      edges3(40'h20, 40'h20, 2, 40'h0, 3);
      idle(40);
      check("R1 repeated edge one line", cnt, c0);
      @(negedge clk); lines = 40'h40;
      idle(12);
      @(negedge clk); lines = '0;
      idle(40);
      check("R1 held line counts once", cnt, c0);
    end
    burst_chk("R1 two lines spread", 10, 2, 5, 1);

    // R3 threshold corners
    cfg(0, 0, 1, 0, 30, 3, 4);
    burst_chk("R3 threshold zero", 0, 1, 0, 1);
    cfg(40, 0, 1, 0, 30, 3, 4);
    burst_chk("R3 threshold forty", 0, 40, 0, 1);
    cfg(41, 0, 1, 0, 30, 3, 4);
    burst_chk("R3 threshold above lines", 0, 40, 0, 0);

    // R4 calibration settings
    cfg(5, 15, 2, 0, 30, 3, 4);
    cal_sel = 1'b1;
    burst_chk("R4 cal threshold", 4, 2, 0, 1);
    burst_chk("R4 cal window", 4, 2, 2, 0);
    cal_sel = 1'b0;
    burst_chk("R4 phys threshold", 4, 2, 0, 0);

    // R5 veto across whole window
    begin
      longint c0; int t0;
      cfg(3, 4, 1, 0, 30, 3, 4);
      c0 = cnt; t0 = trig_n;
      @(negedge clk); veto = 1'b1;
      burst(7, 3, 0);
      idle(10);
      @(negedge clk); veto = 1'b0;
      idle(40);
      check("R5 veto count", cnt, c0);
      check("R5 veto trig", trig_n, t0);
    end

    // R6 dead time d=10: blind cycles 1..12
    begin
      longint c0;
      cfg(1, 0, 1, 0, 10, 0, 0);
      c0 = cnt; edges3(40'h1, 40'h2, 12, 40'h0, 13); idle(40);
      check("R6 edge in last blind cycle", cnt, c0 + 1);
      c0 = cnt; edges3(40'h1, 40'h2, 13, 40'h0, 14); idle(40);
      check("R6 edge after dead time", cnt, c0 + 2);
      cfg(2, 15, 1, 0, 10, 0, 0);
      c0 = cnt; edges3(40'h3, 40'h4, 12, 40'h8, 13); idle(40);
      check("R6 blind edge opens no window", cnt, c0 + 1);
    end

    // R8 pending delay t=20: blind cycles 1..21
    begin
      longint c0; int t0;
      cfg(1, 0, 1, 0, 0, 20, 0);
      c0 = cnt; t0 = trig_n; edges3(40'h1, 40'h2, 21, 40'h0, 22); idle(60);
      check("R8 edge while pending", cnt, c0 + 1);
      check("R8 pulses while pending", trig_n, t0 + 1);
      c0 = cnt; t0 = trig_n; edges3(40'h1, 40'h2, 22, 40'h0, 23); idle(60);
      check("R8 edge at fire cycle", cnt, c0 + 2);
      check("R8 pulses at fire cycle", trig_n, t0 + 2);
    end

    // R9 run gate, R10 clear on change
    begin
      int t0, m0;
      cfg(1, 0, 1, 0, 0, 3, 4);
      @(negedge clk); run = 1'b0;
      @(negedge clk);
      check("R10 clear on stop", cnt, 0);
      t0 = trig_n; m0 = tm_n;
      burst(2, 2, 0);
      idle(30);
      check("R9 counted while stopped", cnt, 1);
      check("R9 no trig while stopped", trig_n, t0);
      check("R9 no tmark while stopped", tm_n, m0);
      @(negedge clk); run = 1'b1;
      @(negedge clk);
      check("R10 clear on start", cnt, 0);
    end

    // random bursts, R1 R2 R4
    for (int it = 0; it < 40; it++) begin
      int n = 1 + $urandom % 6, x = $urandom % 16, k = 1 + $urandom % 8;
      int s = $urandom % 4, b = $urandom % 40, o = $urandom % 16;
      cal_sel = $urandom % 2;
      if (cal_sel) cfg(1 + $urandom % 6, o, n, x, 30, 3, 4);
      else         cfg(n, x, 1 + $urandom % 6, o, 30, 3, 4);
      burst_chk("R1 R2 R4 random burst", b, k, s, predict(n, k, s, x));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule